// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block stores a stream of 32-bit trace frames in an internal circular memory. Capture runs while the enable bit is set. Each valid frame goes to the write pointer, and the pointer then advances and wraps around the memory. A trigger input marks the event of interest. From the frame after the trigger onward, a programmable counter counts down the frames that are still to be kept. When the counter reaches zero, acquisition freezes, so the memory holds a window of history around the trigger.

Software reaches the block through a single-cycle register port. The port carries an address, a data word and a read/write flag, and read data appears one cycle after the access. The port exposes:
- fixed identification, depth and width words,
- a status word with sticky flags for wrap-around, trigger seen and acquisition finished, plus a live copy of the upstream formatter's drained flag,
- software-writable read pointer, write pointer, countdown and control.

Readout goes through an auto-advancing data register, so the host sets the read pointer once and then reads the same address repeatedly. After a wrap, the oldest frame sits at the write pointer. Without a wrap, the valid frames are those below the write pointer.

Top module: `trace_store`

## Requirements
- R1: After reset, the read data output is 0, and status, control, both pointers and the countdown all read back as 0.
- R2: Reads of address 0 return the identification parameter (default 32'h7A3C0001). Reads of address 1 return the memory depth parameter (a power of two, at least 4). Reads of address 2 return 32. Read data is valid in the cycle after the access and holds until the next read.
- R3: While control bit 0 is 1 and acquisition is not finished, each cycle with frame_valid_i high stores frame_i at the write pointer (address 6), and the write pointer then advances by one modulo the depth. While control bit 0 is 0, no frame is stored.
- R4: Status bit 0 (full) is set when a frame is stored at location depth-1. It stays set until the next capture start.
- R5: trigger_i high while control bit 0 is 1 sets status bit 1 (triggered). While control bit 0 is 0, trigger_i has no effect.
- R6: Once the triggered flag is set, each stored frame decrements the countdown (address 7) by one. The frame stored in the trigger cycle itself is not counted. When the countdown reaches 0, no further frames are stored, and status bit 2 (finished) is set in the following cycle.
- R7: Status bit 3 reflects fmt_empty_i at the time of the read access.
- R8: A read of address 4 returns the frame at the read pointer (address 5), and the read pointer then advances by one modulo the depth.
- R9: The read pointer, write pointer and countdown are writable. Pointer writes keep only the low log2(depth) bits.
- R10: Control (address 8) reads back its bits 1:0. Bit 1 selects the demultiplexed port mode and is only stored. Writing a value with bit 0 set while bit 0 is currently 0 clears full, triggered and finished. Writing 0 stops capture and leaves the flags as they are.
- R11: Writes to addresses 0 to 4 change no register, no flag and no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid_i | input | 1 | A trace frame is present on frame_i |
| frame_i | input | 32 | Trace frame |
| trigger_i | input | 1 | Trigger event |
| fmt_empty_i | input | 1 | Upstream formatter holds no pending data |
| reg_en_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read access |

## Verification
The embedded properties check the following on every cycle:
- the write pointer steps by exactly one per stored frame,
- the write pointer stays frozen once acquisition has finished,
- the countdown falls by one per counted frame,
- the full flag is sticky,
- a data-register read advances the read pointer,
- a depth read returns the parameter.

Only the directed scenarios can show which frame lands where. That covers the oldest-first ordering after a wrap, the exclusion of the trigger-cycle frame from the countdown, flag clearing on restart, and the read-only addresses leaving state untouched.

// File: rtl/trace_store_pkg.sv
package trace_store_pkg;
  localparam int FRAME_W = 32;
  localparam int ADDR_W  = 4;

  // Register addresses; the order is the software view of the block
  localparam logic [ADDR_W-1:0] A_IDENT   = 4'd0;
  localparam logic [ADDR_W-1:0] A_DEPTH   = 4'd1;
  localparam logic [ADDR_W-1:0] A_WIDTH   = 4'd2;
  localparam logic [ADDR_W-1:0] A_STATUS  = 4'd3;
  localparam logic [ADDR_W-1:0] A_DATA    = 4'd4;
  localparam logic [ADDR_W-1:0] A_RDPTR   = 4'd5;
  localparam logic [ADDR_W-1:0] A_WRPTR   = 4'd6;
  localparam logic [ADDR_W-1:0] A_COUNT   = 4'd7;
  localparam logic [ADDR_W-1:0] A_CONTROL = 4'd8;

  typedef struct packed {
    logic drained;
    logic finished;
    logic triggered;
    logic full;
  } stat_t;
endpackage

// File: rtl/trace_store_ram.sv
module trace_store_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/trace_store_acq.sv
module trace_store_acq #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic             frame_valid,
  input  logic             trigger,
  input  logic             wp_we,
  input  logic [PTR_W-1:0] wp_wval,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wval,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             triggered,
  output logic             finished,
  output logic             ram_we
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wp_q, wp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic full_q, full_d, trig_q, trig_d, fin_q, fin_d;
  logic exhausted;

  assign exhausted = trig_q && (cnt_q == '0);
  assign ram_we    = run && frame_valid && !fin_q && !exhausted;

  always_comb begin
    wp_d   = wp_q;
    cnt_d  = cnt_q;
    full_d = full_q;
    trig_d = trig_q;
    fin_d  = fin_q;
    if (start) begin
      full_d = 1'b0;
      trig_d = 1'b0;
      fin_d  = 1'b0;
    end else begin
      if (ram_we && (wp_q == LAST)) full_d = 1'b1;
      if (run && trigger)           trig_d = 1'b1;
      if (run && exhausted)         fin_d  = 1'b1;
    end
    if (wp_we)       wp_d = wp_wval;
    else if (ram_we) wp_d = wp_q + PTR_W'(1);
    if (cnt_we)                      cnt_d = cnt_wval;
    else if (ram_we && trig_q)       cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      trig_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      wp_q   <= wp_d;
      cnt_q  <= cnt_d;
      full_q <= full_d;
      trig_q <= trig_d;
      fin_q  <= fin_d;
    end
  end

  assign wr_ptr    = wp_q;
  assign count     = cnt_q;
  assign full      = full_q;
  assign triggered = trig_q;
  assign finished  = fin_q;

  // R3
  wp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !wp_we) |=> (wr_ptr == $past(wr_ptr) + PTR_W'(1)));
  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && !wp_we) |=> $stable(wr_ptr));
  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && triggered && !cnt_we) |=> (count == $past(count) - CNT_W'(1)));
  // R4
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !start) |=> full);
endmodule

// File: rtl/trace_store_regs.sv
module trace_store_regs
  import trace_store_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter int          CNT_W    = 32,
  parameter logic [31:0] ID_VALUE = 32'h7A3C_0001,
  localparam int         PTR_W    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_en,
  input  logic               acc_wr,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [1:0]         wdata_ctrl,
  input  logic [PTR_W-1:0]   wdata_ptr,
  output logic [FRAME_W-1:0] acc_rdata,
  input  logic [FRAME_W-1:0] ram_frame,
  output logic [PTR_W-1:0]   rd_ptr,
  input  logic [PTR_W-1:0]   wr_ptr,
  input  logic [CNT_W-1:0]   count,
  input  stat_t              stat,
  output logic               run,
  output logic               start,
  output logic               wp_we,
  output logic               cnt_we
);
  logic rd_acc, wr_acc;
  logic [1:0] ctrl_q, ctrl_d;
  logic [PTR_W-1:0] rp_q, rp_d;
  logic [FRAME_W-1:0] rdata_q, rdata_d, rmux;

  assign rd_acc = acc_en && !acc_wr;
  assign wr_acc = acc_en && acc_wr;
  assign start  = wr_acc && (acc_addr == A_CONTROL) && wdata_ctrl[0] && !ctrl_q[0];
  assign wp_we  = wr_acc && (acc_addr == A_WRPTR);
  assign cnt_we = wr_acc && (acc_addr == A_COUNT);

  always_comb begin
    case (acc_addr)
      A_IDENT:   rmux = ID_VALUE;
      A_DEPTH:   rmux = FRAME_W'(DEPTH);
      A_WIDTH:   rmux = FRAME_W'(FRAME_W);
      A_STATUS:  rmux = FRAME_W'(stat);
      A_DATA:    rmux = ram_frame;
      A_RDPTR:   rmux = FRAME_W'(rp_q);
      A_WRPTR:   rmux = FRAME_W'(wr_ptr);
      A_COUNT:   rmux = FRAME_W'(count);
      A_CONTROL: rmux = FRAME_W'(ctrl_q);
      default:   rmux = '0;
    endcase
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    rp_d    = rp_q;
    rdata_d = rdata_q;
    if (wr_acc && (acc_addr == A_CONTROL)) ctrl_d = wdata_ctrl;
    if (wr_acc && (acc_addr == A_RDPTR))      rp_d = wdata_ptr;
    else if (rd_acc && (acc_addr == A_DATA))  rp_d = rp_q + PTR_W'(1);
    if (rd_acc) rdata_d = rmux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rp_q    <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      rp_q    <= rp_d;
      rdata_q <= rdata_d;
    end
  end

  assign run       = ctrl_q[0];
  assign rd_ptr    = rp_q;
  assign acc_rdata = rdata_q;

  // R8
  rp_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && (acc_addr == A_DATA)) |=> (rd_ptr == $past(rd_ptr) + PTR_W'(1)));
  // R2
  depth_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && (acc_addr == A_DEPTH)) |=> (acc_rdata == FRAME_W'(DEPTH)));
  // R10
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!stat.full && !stat.triggered && !stat.finished));
endmodule

// File: rtl/trace_store.sv
module trace_store
  import trace_store_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter int          CNT_W    = 32,
  parameter logic [31:0] ID_VALUE = 32'h7A3C_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_valid_i,
  input  logic [31:0] frame_i,
  input  logic        trigger_i,
  input  logic        fmt_empty_i,
  input  logic        reg_en_i,
  input  logic        reg_wr_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0]   rd_ptr, wr_ptr;
  logic [CNT_W-1:0]   count;
  logic [FRAME_W-1:0] ram_frame;
  logic run, start, wp_we, cnt_we, ram_we;
  logic full, triggered, finished;
  stat_t stat;

  assign stat = '{drained: fmt_empty_i, finished: finished,
                  triggered: triggered, full: full};

  trace_store_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .acc_en(reg_en_i), .acc_wr(reg_wr_i), .acc_addr(reg_addr_i),
    .wdata_ctrl(reg_wdata_i[1:0]), .wdata_ptr(reg_wdata_i[PTR_W-1:0]),
    .acc_rdata(reg_rdata_o), .ram_frame(ram_frame), .rd_ptr(rd_ptr),
    .wr_ptr(wr_ptr), .count(count), .stat(stat),
    .run(run), .start(start), .wp_we(wp_we), .cnt_we(cnt_we)
  );

  trace_store_acq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_acq (
    .clk(clk), .rst_n(rst_n), .run(run), .start(start),
    .frame_valid(frame_valid_i), .trigger(trigger_i),
    .wp_we(wp_we), .wp_wval(reg_wdata_i[PTR_W-1:0]),
    .cnt_we(cnt_we), .cnt_wval(reg_wdata_i[CNT_W-1:0]),
    .wr_ptr(wr_ptr), .count(count), .full(full),
    .triggered(triggered), .finished(finished), .ram_we(ram_we)
  );

  trace_store_ram #(.DEPTH(DEPTH), .DW(FRAME_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(wr_ptr), .wdata(frame_i),
    .raddr(rd_ptr), .rdata(ram_frame)
  );
endmodule

// File: tb/trace_store_test.sv
module trace_store_test;
  localparam int DEPTH = 8;
  localparam logic [31:0] ID = 32'h7A3C_0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_valid_i = 1'b0, trigger_i = 1'b0, fmt_empty_i = 1'b0;
  logic [31:0] frame_i = '0;
  logic reg_en_i = 1'b0, reg_wr_i = 1'b0;
  logic [3:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  trace_store #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .frame_valid_i(frame_valid_i), .frame_i(frame_i),
    .trigger_i(trigger_i), .fmt_empty_i(fmt_empty_i), .reg_en_i(reg_en_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_en_i = 1'b1; reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_en_i = 1'b0; reg_wr_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en_i = 1'b1; reg_wr_i = 1'b0; reg_addr_i = a;
    @(negedge clk);
    reg_en_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic push(logic [31:0] f, logic t);
    @(negedge clk);
    frame_valid_i = 1'b1; frame_i = f; trigger_i = t;
    @(negedge clk);
    frame_valid_i = 1'b0; trigger_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 rdata", reg_rdata_o, 32'h0);
    rd(4'd3, v); check("R1 status", v, 32'h0);
    rd(4'd8, v); check("R1 control", v, 32'h0);
    rd(4'd5, v); check("R1 rdptr", v, 32'h0);
    rd(4'd6, v); check("R1 wrptr", v, 32'h0);
    rd(4'd7, v); check("R1 count", v, 32'h0);
  endtask

  task automatic t_ident();
    logic [31:0] v;
    rd(4'd0, v); check("R2 ident", v, ID);
    rd(4'd1, v); check("R2 depth", v, DEPTH);
    rd(4'd2, v); check("R2 width", v, 32);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    wr(4'd5, 32'd1);
    wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'h3); wr(4'd2, 32'h5);
    wr(4'd3, 32'hF); wr(4'd4, 32'h55);
    rd(4'd0, v); check("R11 ident kept", v, ID);
    rd(4'd1, v); check("R11 depth kept", v, DEPTH);
    rd(4'd2, v); check("R11 width kept", v, 32);
    rd(4'd3, v); check("R11 status kept", v, 32'h0);
    rd(4'd5, v); check("R11 rdptr kept after data write", v, 32'd1);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    wr(4'd6, 0); wr(4'd8, 1);
    for (int i = 0; i < 3; i++) push(32'hA000_0000 + i, 1'b0);
    rd(4'd6, v); check("R3 wrptr after 3", v, 3);
    rd(4'd3, v); check("R4 not full", v, 0);
    wr(4'd8, 0);
    push(32'hDEAD_BEEF, 1'b0);
    rd(4'd6, v); check("R3 disabled no store", v, 3);
    wr(4'd5, 0);
    for (int i = 0; i < 3; i++) begin
      rd(4'd4, v); check("R8 frame", v, 32'hA000_0000 + i);
    end
    rd(4'd5, v); check("R8 rdptr advanced", v, 3);
    fmt_empty_i = 1'b1;
    rd(4'd3, v); check("R7 drained bit", v, 32'h8);
    fmt_empty_i = 1'b0;
    rd(4'd3, v); check("R7 drained low", v, 32'h0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(4'd6, 0); wr(4'd8, 1);
    for (int i = 0; i < 10; i++) push(32'hB000_0000 + i, 1'b0);
    rd(4'd6, v); check("R3 wrptr wrapped", v, 2);
    rd(4'd3, v); check("R4 full set", v, 32'h1);
    wr(4'd5, 2);
    for (int i = 0; i < 8; i++) begin
      rd(4'd4, v); check("R8 oldest-first", v, 32'hB000_0002 + i);
    end
    rd(4'd5, v); check("R8 rdptr wraps", v, 2);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    wr(4'd8, 0);
    rd(4'd3, v); check("R10 stop keeps flags", v, 32'h1);
    wr(4'd8, 1);
    rd(4'd3, v); check("R10 start clears", v, 32'h0);
    wr(4'd8, 0);
    @(negedge clk); trigger_i = 1'b1;
    @(negedge clk); trigger_i = 1'b0;
    rd(4'd3, v); check("R5 trigger ignored when off", v, 32'h0);
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    wr(4'd6, 0); wr(4'd7, 3); wr(4'd8, 1);
    push(32'hC000_0000, 1'b1);
    rd(4'd3, v); check("R5 triggered", v, 32'h2);
    for (int i = 1; i < 6; i++) push(32'hC000_0000 + i, 1'b0);
    rd(4'd6, v); check("R6 stored count", v, 4);
    rd(4'd7, v); check("R6 countdown zero", v, 0);
    rd(4'd3, v); check("R6 finished", v, 32'h6);
    wr(4'd5, 0);
    for (int i = 0; i < 4; i++) begin
      rd(4'd4, v); check("R6 kept frames", v, 32'hC000_0000 + i);
    end
    wr(4'd8, 0);
  endtask

  task automatic t_sw_regs();
    logic [31:0] v;
    wr(4'd5, 13);           rd(4'd5, v); check("R9 rdptr mod", v, 5);
    wr(4'd6, 32'hFFFF_FFF9); rd(4'd6, v); check("R9 wrptr mod", v, 1);
    wr(4'd7, 32'h1234);     rd(4'd7, v); check("R9 count", v, 32'h1234);
    wr(4'd8, 32'hFF);       rd(4'd8, v); check("R10 ctrl bits", v, 3);
    wr(4'd8, 0);            rd(4'd8, v); check("R10 ctrl stop", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all-requirements actual=hang expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_readonly();
    t_capture();
    t_wrap();
    t_restart();
    t_trigger();
    t_sw_regs();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule